// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a small processor core that runs a fixed 16-bit instruction set, one instruction at a time, over several clock cycles. It holds eight 16-bit general registers, a program counter, an instruction register and a three-bit condition code that records whether the last value written to a register was negative, zero or positive. All instructions and data come from one single-port synchronous memory of 64K 16-bit words. The memory returns read data one cycle after the address is presented.

Each instruction is fetched and decoded, and the program counter is incremented. The core then forms the effective address and performs any memory reads. Last, it executes and writes back. The operations are: add, bitwise AND and bitwise NOT on registers; loads and stores that use PC-relative, memory-indirect or base-plus-offset addressing; a load-effective-address; a branch that tests a mask against the condition code; and a register jump. A halt input holds the core at an instruction boundary. An unused opcode stops the core for good, which is how a test program ends.

Top module: `mc16_core`

## Requirements
- R1: On a cycle with `rst` high, the PC is set to `RESET_PC` (default x3000), all registers are cleared and the condition code is set to Z. In the first cycle after reset, `mem_addr` equals `RESET_PC` and `mem_we` is low.
- R2: Every instruction starts with a read of the word at PC. PC then becomes PC+1, and every PC-relative offset is added to that incremented value.
- R3: ADD (opcode 0001) and AND (opcode 0101) write DR = IR[11:9] with SR1 = IR[8:6] combined with SR2 = IR[2:0]. When IR[5] = 1, the second operand is IR[4:0] sign-extended instead. No other register changes.
- R4: NOT (opcode 1001) writes the bitwise complement of SR1 = IR[8:6] into DR.
- R5: The condition code holds N in bit 2, Z in bit 1 and P in bit 0, and exactly one bit is always set. It is set from the sign of the value written by ADD, AND, NOT, LD, LDI, LDR and LEA. ST, STI, STR, BR and JMP leave it unchanged.
- R6: LD (0010) loads DR from address PC+SEXT(IR[8:0]). LDR (0110) loads DR from address R[IR[8:6]]+SEXT(IR[5:0]).
- R7: LDI (1010) and STI (1011) first read a pointer at PC+SEXT(IR[8:0]). They then load DR from, or store SR to, the address held in that pointer.
- R8: ST (0011) and STR (0111) write SR = IR[11:9] to PC+SEXT(IR[8:0]) or to R[IR[8:6]]+SEXT(IR[5:0]). `mem_we` stays high for exactly one cycle per store.
- R9: LEA (1110) writes PC+SEXT(IR[8:0]) into DR and makes no data memory access.
- R10: BR (0000) takes bits IR[11:9] as an n/z/p mask. If the mask shares a set bit with the condition code, PC becomes PC+SEXT(IR[8:0]). Otherwise execution falls through, and a mask of 000 is never taken.
- R11: JMP (1100) loads PC with R[IR[8:6]].
- R12: While `halt` is high at an instruction boundary, no fetch starts and PC holds. When `halt` is released, execution resumes at that PC.
- R13: Opcodes 0100, 1000, 1101 and 1111 stop the core permanently. After such an opcode, no further instruction runs, `mem_we` stays low and `mem_addr` holds still.
- R14: A counted loop at x3000 sums twelve words at x3100..x310B into a register and stores the sum after the array. The stored word equals the 16-bit sum of those words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Hold the core before the next fetch |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |

## Verification
The assertions check on every cycle that exactly one condition flag is set and that stores and branches never disturb it. They also check that decode advances PC by one, that a store strobe lasts a single cycle, that only the destination register changes on a write, and that halt and the illegal-opcode stop freeze the core. Only the bench's programs can show the values themselves: arithmetic results, sign-extended offsets, the three addressing flavours, the extra pointer read of indirect accesses, and the branch-mask decisions. The bench observes these through memory, including flag values that it brings out by a chain of conditional branches that store distinct codes.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

    localparam int XLEN  = 16;
    localparam int REG_N = 8;
    localparam int RA_W  = $clog2(REG_N);

    localparam logic [3:0] OP_BR  = 4'b0000;
    localparam logic [3:0] OP_ADD = 4'b0001;
    localparam logic [3:0] OP_LD  = 4'b0010;
    localparam logic [3:0] OP_ST  = 4'b0011;
    localparam logic [3:0] OP_AND = 4'b0101;
    localparam logic [3:0] OP_LDR = 4'b0110;
    localparam logic [3:0] OP_STR = 4'b0111;
    localparam logic [3:0] OP_NOT = 4'b1001;
    localparam logic [3:0] OP_LDI = 4'b1010;
    localparam logic [3:0] OP_STI = 4'b1011;
    localparam logic [3:0] OP_JMP = 4'b1100;
    localparam logic [3:0] OP_LEA = 4'b1110;

    localparam logic [2:0] CC_Z = 3'b010;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_EXEC, S_IND, S_INDW, S_RD, S_WB, S_WR, S_STALL
    } state_e;

    typedef enum logic [1:0] { ALU_ADD, ALU_AND, ALU_NOT } alu_op_e;

    typedef struct packed {
        logic [3:0]      op;
        logic [RA_W-1:0] dst;     // also store source and branch mask
        logic [RA_W-1:0] src1;    // also base register
        logic [RA_W-1:0] src2;
        logic            use_imm;
        logic [XLEN-1:0] imm;
        logic [XLEN-1:0] off6;
        logic [XLEN-1:0] off9;
    } decoded_t;

    function automatic decoded_t decode(input logic [XLEN-1:0] ir);
        decoded_t d;
        d.op      = ir[15:12];
        d.dst     = ir[11:9];
        d.src1    = ir[8:6];
        d.src2    = ir[2:0];
        d.use_imm = ir[5];
        d.imm     = {{(XLEN-5){ir[4]}}, ir[4:0]};
        d.off6    = {{(XLEN-6){ir[5]}}, ir[5:0]};
        d.off9    = {{(XLEN-9){ir[8]}}, ir[8:0]};
        return d;
    endfunction

    function automatic logic [2:0] cc_of(input logic [XLEN-1:0] v);
        if (v[XLEN-1])    return 3'b100;
        else if (v == '0) return 3'b010;
        else              return 3'b001;
    endfunction

    function automatic logic is_store(input logic [3:0] op);
        return (op == OP_ST) || (op == OP_STR) || (op == OP_STI);
    endfunction

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
    parameter int XLEN  = 16,
    parameter int REG_N = 8,
    localparam int AW   = $clog2(REG_N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] regs [REG_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

    for (genvar g = 0; g < REG_N; g++) begin : g_hold
        AST_ONLY_DST_CHANGES: assert property (@(posedge clk) disable iff (rst)
            !(we && wa == AW'(g)) |=> $stable(regs[g]))
            else $error("register %0d changed without a write", g); // R3
    end
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
    import mc16_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            default: y = ~a;
        endcase
    end
endmodule

// File: rtl/mc16_agu.sv
module mc16_agu
    import mc16_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] off6,
    input  logic [XLEN-1:0] off9,
    input  logic            use_base,
    input  logic [2:0]      mask,
    input  logic [2:0]      cc,
    output logic [XLEN-1:0] ea,
    output logic            take
);
    always_comb begin
        ea   = use_base ? (base + off6) : (pc + off9);
        take = |(mask & cc);
    end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
    import mc16_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h3000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        halt,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        mem_we,
    input  logic [15:0] mem_rdata
);
    state_e          state;
    logic [XLEN-1:0] pc, ir, mar;
    logic [2:0]      cc;
    decoded_t        dec;

    logic [XLEN-1:0] rd1, rd2, alu_y, ea, rf_wd;
    logic            rf_we, br_take;
    alu_op_e         alu_op;

    assign dec = decode(ir);

    mc16_regfile #(.XLEN(XLEN), .REG_N(REG_N)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (dec.src1),
        .ra2 (is_store(dec.op) ? dec.dst : dec.src2),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (rf_we),
        .wa  (dec.dst),
        .wd  (rf_wd)
    );

    always_comb begin
        case (dec.op)
            OP_ADD:  alu_op = ALU_ADD;
            OP_AND:  alu_op = ALU_AND;
            default: alu_op = ALU_NOT;
        endcase
    end

    mc16_alu u_alu (
        .op (alu_op),
        .a  (rd1),
        .b  (dec.use_imm ? dec.imm : rd2),
        .y  (alu_y)
    );

    mc16_agu u_agu (
        .pc       (pc),
        .base     (rd1),
        .off6     (dec.off6),
        .off9     (dec.off9),
        .use_base ((dec.op == OP_LDR) || (dec.op == OP_STR)),
        .mask     (dec.dst),
        .cc       (cc),
        .ea       (ea),
        .take     (br_take)
    );

    // register write-back selection
    always_comb begin
        rf_we = 1'b0;
        rf_wd = alu_y;
        if (state == S_EXEC) begin
            case (dec.op)
                OP_ADD, OP_AND, OP_NOT: rf_we = 1'b1;
                OP_LEA: begin rf_we = 1'b1; rf_wd = ea; end
                default: ;
            endcase
        end else if (state == S_WB) begin
            rf_we = 1'b1;
            rf_wd = mem_rdata;
        end
    end

    assign mem_addr  = (state == S_FETCH) ? pc : mar;
    assign mem_we    = (state == S_WR);
    assign mem_wdata = rd2;

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_FETCH;
            pc    <= RESET_PC;
            ir    <= '0;
            mar   <= '0;
            cc    <= CC_Z;
        end else begin
            if (rf_we) cc <= cc_of(rf_wd);
            case (state)
                S_FETCH:  if (!halt) state <= S_DECODE;
                S_DECODE: begin
                    ir    <= mem_rdata;
                    pc    <= pc + 1'b1;
                    state <= S_EXEC;
                end
                S_EXEC: begin
                    case (dec.op)
                        OP_ADD, OP_AND, OP_NOT, OP_LEA: state <= S_FETCH;
                        OP_BR: begin
                            if (br_take) pc <= ea;
                            state <= S_FETCH;
                        end
                        OP_JMP: begin
                            pc    <= rd1;
                            state <= S_FETCH;
                        end
                        OP_LD, OP_LDR: begin mar <= ea; state <= S_RD;  end
                        OP_LDI, OP_STI: begin mar <= ea; state <= S_IND; end
                        OP_ST, OP_STR: begin mar <= ea; state <= S_WR;  end
                        default: state <= S_STALL;
                    endcase
                end
                S_IND:  state <= S_INDW;
                S_INDW: begin
                    mar   <= mem_rdata;
                    state <= (dec.op == OP_LDI) ? S_RD : S_WR;
                end
                S_RD:   state <= S_WB;
                S_WB:   state <= S_FETCH;
                S_WR:   state <= S_FETCH;
                default: state <= S_STALL;
            endcase
        end
    end

    AST_CC_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(cc) == 1) else $error("condition code not one-hot"); // R5

    AST_CC_KEPT: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && (is_store(dec.op) || dec.op == OP_BR || dec.op == OP_JMP))
        |=> $stable(cc)) else $error("flags changed by store or branch"); // R5

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        state == S_DECODE |=> pc == $past(pc) + 16'd1)
        else $error("PC did not step by one"); // R2

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we) else $error("store strobe longer than a cycle"); // R8

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH && halt) |=> (state == S_FETCH && $stable(pc)))
        else $error("core moved while halted"); // R12

    AST_STALL_STICKY: assert property (@(posedge clk) disable iff (rst)
        state == S_STALL |=> (state == S_STALL && !mem_we && $stable(mem_addr)))
        else $error("core left the stop state"); // R13
endmodule

// File: tb/mc16_core_tb.sv
module mc16_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_AW     = 12;
    localparam int MEM_WORDS  = 1 << MEM_AW;
    localparam int N_VEC      = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    logic              ld_en = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [15:0]       ld_data = '0;
    logic [15:0]       mem [MEM_WORDS];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc16_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .halt      (halt),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    // bench memory, address aliased on the low MEM_AW bits, one cycle read latency
    always_ff @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[MEM_AW-1:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[MEM_AW-1:0]];
    end

    // instruction, R1 init, R2 init, checked address, expected word, expected flag code, requirement
    typedef struct packed {
        logic [15:0] instr;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] chk;
        logic [15:0] exp;
        logic [2:0]  cc;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{16'h1642, 16'h0005, 16'h0007, 16'h3032, 16'h000C, 3'b001, 4'd3},  // R3 ADD reg
        '{16'h167B, 16'h0003, 16'h0000, 16'h3032, 16'hFFFE, 3'b100, 4'd3},  // R3 ADD imm -5
        '{16'h1642, 16'h7FFF, 16'h0001, 16'h3032, 16'h8000, 3'b100, 4'd5},  // R5 wrap to negative
        '{16'h5642, 16'hF0F0, 16'h0F0F, 16'h3032, 16'h0000, 3'b010, 4'd3},  // R3 AND reg, zero
        '{16'h567F, 16'h8001, 16'h0000, 16'h3032, 16'h8001, 3'b100, 4'd3},  // R3 AND imm -1
        '{16'h967F, 16'h00FF, 16'h0000, 16'h3032, 16'hFF00, 3'b100, 4'd4},  // R4 NOT
        '{16'h967F, 16'hFFFF, 16'h0000, 16'h3032, 16'h0000, 3'b010, 4'd4},  // R4 NOT to zero
        '{16'hE605, 16'h0000, 16'h0000, 16'h3032, 16'h300B, 3'b001, 4'd9},  // R9 LEA +5
        '{16'hE7FA, 16'h0000, 16'h0000, 16'h3032, 16'h3000, 3'b001, 4'd9},  // R9 LEA -6
        '{16'h262B, 16'h0000, 16'h7FFF, 16'h3032, 16'h7FFF, 3'b001, 4'd6},  // R6 LD
        '{16'h6641, 16'h3030, 16'h8123, 16'h3032, 16'h8123, 3'b100, 4'd6},  // R6 LDR +1
        '{16'h6660, 16'h3051, 16'h0000, 16'h3032, 16'h0000, 3'b010, 4'd6},  // R6 LDR -32
        '{16'hA62A, 16'h3031, 16'h4444, 16'h3032, 16'h4444, 3'b001, 4'd7},  // R7 LDI
        '{16'h342F, 16'h0000, 16'h1234, 16'h3035, 16'h1234, 3'b001, 4'd8},  // R8 ST
        '{16'h7444, 16'h3030, 16'hBEEF, 16'h3034, 16'hBEEF, 3'b001, 4'd8},  // R8 STR
        '{16'hB42A, 16'h3036, 16'h5A5A, 16'h3036, 16'h5A5A, 3'b001, 4'd7},  // R7 STI
        '{16'h0001, 16'h0000, 16'h0000, 16'h3032, 16'h0000, 3'b001, 4'd10}, // R10 mask 000
        '{16'h0201, 16'h0000, 16'h0000, 16'h3032, 16'hDEAD, 3'b001, 4'd10}, // R10 p taken
        '{16'h0C01, 16'h0000, 16'h0000, 16'h3032, 16'h0000, 3'b001, 4'd10}, // R10 nz not taken
        '{16'hC040, 16'h3007, 16'h0000, 16'h3032, 16'hDEAD, 3'b001, 4'd11}  // R11 JMP
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] addr, input logic [15:0] data);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = addr[MEM_AW-1:0];
        ld_data = data;
    endtask

    task automatic put_done();
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic logic [15:0] rd(input logic [15:0] addr);
        return mem[addr[MEM_AW-1:0]];
    endfunction

    // harness program: R1,R2 loaded, flag markers, test instruction, value and flag dump
    function automatic logic [15:0] harness(input int k, input logic [15:0] t);
        case (k)
            0:  return 16'h222F;  // LD R1, x3030
            1:  return 16'h242F;  // LD R2, x3031
            2:  return 16'h1B24;  // ADD R5,R4,#4
            3:  return 16'h1D22;  // ADD R6,R4,#2
            4:  return 16'h1F21;  // ADD R7,R4,#1
            5:  return t;
            6:  return 16'h362B;  // ST R3, x3032
            7:  return 16'h0802;  // BRn x300A
            8:  return 16'h0403;  // BRz x300C
            9:  return 16'h0204;  // BRp x300E
            10: return 16'h3A28;  // ST R5, x3033
            11: return 16'h8000;  // stop
            12: return 16'h3C26;  // ST R6, x3033
            13: return 16'h4000;  // stop
            14: return 16'h3E24;  // ST R7, x3033
            default: return 16'hF025; // stop
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] sum, held;
        bit          quiet;

        // reset state
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(mem_addr == 16'h3000 && !mem_we, "R1", mem_addr, 16'h3000);

        // table of instruction vectors
        for (int v = 0; v < N_VEC; v++) begin
            rst = 1'b1;
            for (int k = 0; k < 16; k++) put(16'h3000 + 16'(k), harness(k, VECS[v].instr));
            put(16'h3030, VECS[v].a);
            put(16'h3031, VECS[v].b);
            for (int k = 2; k < 7; k++) put(16'h3030 + 16'(k), 16'hDEAD);
            put_done();
            @(negedge clk);
            rst = 1'b0;
            check(mem_addr == 16'h3000 && !mem_we, "R1", mem_addr, 16'h3000);
            repeat (250) @(negedge clk);
            check(rd(VECS[v].chk) == VECS[v].exp, $sformatf("R%0d value", VECS[v].req),
                  rd(VECS[v].chk), VECS[v].exp);
            check(rd(16'h3033) == {13'b0, VECS[v].cc}, "R5 flags", rd(16'h3033),
                  {13'b0, VECS[v].cc});
        end

        // R14 acceptance loop, started under halt (R12)
        rst  = 1'b1;
        halt = 1'b1;
        put(16'h3000, 16'hE2FF); put(16'h3001, 16'h56E0); put(16'h3002, 16'h54A0);
        put(16'h3003, 16'h14AC); put(16'h3004, 16'h0405); put(16'h3005, 16'h6840);
        put(16'h3006, 16'h16C4); put(16'h3007, 16'h1261); put(16'h3008, 16'h14BF);
        put(16'h3009, 16'h0FFA); put(16'h300A, 16'h7640); put(16'h300B, 16'hD000);
        put(16'h300C, 16'h7641);
        sum = '0;
        for (int i = 0; i < 12; i++) begin
            logic [15:0] d;
            d = 16'h0123 * 16'(i + 1) ^ ((i % 3 == 0) ? 16'h8000 : 16'h0000);
            sum = sum + d;
            put(16'h3100 + 16'(i), d);
        end
        put(16'h310C, 16'hDEAD);
        put(16'h310D, 16'hDEAD);
        put_done();
        @(negedge clk);
        rst = 1'b0;
        quiet = 1'b1;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (mem_we || mem_addr != 16'h3000) quiet = 1'b0;
        end
        check(quiet, "R12 halted bus", mem_addr, 16'h3000);
        check(rd(16'h310C) == 16'hDEAD, "R12 nothing ran", rd(16'h310C), 16'hDEAD);
        halt = 1'b0;
        repeat (1500) @(negedge clk);
        check(rd(16'h310C) == sum, "R14 sum", rd(16'h310C), sum);
        check(rd(16'h310D) == 16'hDEAD, "R13 no step past stop", rd(16'h310D), 16'hDEAD);
        held  = mem_addr;
        quiet = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (mem_we || mem_addr != held) quiet = 1'b0;
        end
        check(quiet, "R13 bus frozen", mem_addr, held);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule